// File: doc/BRIEF.md
# Least-Squares Edge Timestamp Frequency Estimator

This block measures the period of a slow, stable input signal far more finely than a simple start-to-stop cycle count would allow. After an arming pulse it stamps every qualifying rising edge of the input with the value of a free-running system-clock counter. It then fits a straight line through the pairs (sample index, elapsed cycles since the first edge) by least squares. The slope of that line is the period. The block keeps only three running quantities while edges arrive: the sample count, the sum of the elapsed times, and the index-weighted sum of the elapsed times. The index sums are produced in closed form at the end.

Collection stops once the programmed number of samples is reached, when a cycle budget runs out, or if the weighted sum would turn negative. A sequential restoring divider then produces the integer period in system-clock cycles. The same divider then produces a 32-bit binary fraction equal to one over the period. Multiplying the system clock frequency by that fraction and keeping the upper 32 bits of the product gives the input frequency. A halved-rate mode stamps only every second input period, which allows faster inputs; the fit coefficients change to suit.

Top module: `lse_freq_est`

## Requirements
- R1: The input passes through a two-flop synchroniser and a rising-edge detector. With halve_rate=0 every detected rising edge is a sample. With halve_rate=1 only the 1st, 3rd, 5th, ... rising edges after arming are samples.
- R2: Sample k (X = k, k = 1..N) carries Y = counter value at its edge minus counter value at sample 1, modulo 2^TS_W, so that sample 1 is the reference with Y = 0. The period output is floor((A·ΣXY − B·(N+1)·ΣY) / (N·(N+1)·(N−1))). A=12 and B=6 when halve_rate=0; A=6 and B=3 when halve_rate=1. The result saturates to all ones at TS_W bits.
- R3: Collection ends as soon as N equals sample_count. The block then reports done=1, timeout=0 and n_used=N.
- R4: inv_period_frac = floor(2^32 · N·(N+1)·(N−1) / (A·ΣXY − B·(N+1)·ΣY)), saturated to 2^32−1.
- R5: If timeout_limit cycles pass after arming before sample_count samples are collected, collection stops and the result is computed from the samples taken so far. The block reports done=1, timeout=1 and n_used equal to that count.
- R6: When N < 3 (or the fit numerator is not positive), error=1 and period and inv_period_frac are 0. done is still raised.
- R7: A start pulse in the idle state clears done, timeout, error, n_used, period and inv_period_frac in the next cycle and arms the block. A start pulse while a measurement is running is ignored. Results stay unchanged until the next accepted start.
- R8: After reset all outputs are 0.
- R9: A measurement whose edges straddle a wrap of the system-clock counter gives the same result as one that does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also drives the timestamp counter |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sig_in | input | 1 | Asynchronous signal whose period is measured |
| start | input | 1 | One-cycle arming pulse |
| sample_count | input | CNT_W | Number of samples to collect, including the reference |
| halve_rate | input | 1 | 1: stamp every second input period |
| timeout_limit | input | TO_W | Cycle budget from arming to the end of collection |
| period | output | TS_W | Fitted period in system-clock cycles |
| inv_period_frac | output | FRAC_W | One over the fitted period as a 32-bit fraction |
| n_used | output | CNT_W | Number of samples used in the fit |
| done | output | 1 | Result valid; held until the next accepted start |
| timeout | output | 1 | Collection ended on the cycle budget |
| error | output | 1 | Too few samples for a fit |

## Verification
Constant-period trains in both rate modes check the exact slope, since a perfect line must give an integer period and its exact reciprocal. Jittered random trains of random length and rate mode separate the full regression from cruder fits, because jitter shifts the offset term. Short trains that run into the cycle budget tell a timeout apart from normal completion, and trains with fewer than three samples tell the error path apart from a fit. A run that straddles the counter wrap and a run with a stray start pulse show that neither event disturbs the result.

// File: rtl/lse_pkg.sv
package lse_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREF,
    ST_COLL,
    ST_CALC,
    ST_LD1,
    ST_WT1,
    ST_LD2,
    ST_WT2
  } lse_st_e;
endpackage

// File: rtl/lse_edge_sync.sv
module lse_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  input  logic arm,
  input  logic halve,
  output logic ev
);
  logic [2:0] sh_q, sh_d;
  logic       ph_q, ph_d;
  logic       rise;

  always_comb begin
    sh_d = {sh_q[1:0], sig_in};
    rise = sh_q[1] & ~sh_q[2];
    ev   = rise & (~halve | ~ph_q);
    ph_d = ph_q;
    if (arm)       ph_d = 1'b0;
    else if (rise) ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      ph_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      ph_q <= ph_d;
    end
  end

  // R1: detected rising edges can never occur on two adjacent cycles
  a_r1_event_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> !ev);
endmodule

// File: rtl/lse_accum.sv
module lse_accum #(
  parameter int TS_W  = 32,
  parameter int CNT_W = 16,
  parameter int ACC_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ref_ld,
  input  logic             take,
  input  logic [TS_W-1:0]  stamp,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] n,
  output logic [ACC_W-1:0] sum_y,
  output logic [ACC_W-1:0] sum_xy,
  output logic             neg_stop
);
  logic [TS_W-1:0]  ref_q, ref_d;
  logic [CNT_W-1:0] n_q, n_d, x;
  logic [ACC_W-1:0] sy_q, sy_d, sxy_q, sxy_d;
  logic [TS_W-1:0]  y;
  logic [ACC_W-1:0] prod, sxy_nxt, sy_nxt;

  always_comb begin
    y        = stamp - ref_q;
    x        = n_q + CNT_W'(1);
    prod     = ACC_W'(x) * ACC_W'(y);
    sxy_nxt  = sxy_q + prod;
    sy_nxt   = sy_q + ACC_W'(y);
    neg_stop = sxy_nxt[ACC_W-1];
    ref_d = ref_q;
    n_d   = n_q;
    sy_d  = sy_q;
    sxy_d = sxy_q;
    if (clr) begin
      n_d   = '0;
      sy_d  = '0;
      sxy_d = '0;
    end else if (ref_ld) begin
      ref_d = stamp;
      n_d   = CNT_W'(1);
      sy_d  = '0;
      sxy_d = '0;
    end else if (take && !neg_stop) begin
      n_d   = x;
      sy_d  = sy_nxt;
      sxy_d = sxy_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      n_q   <= '0;
      sy_q  <= '0;
      sxy_q <= '0;
    end else begin
      ref_q <= ref_d;
      n_q   <= n_d;
      sy_q  <= sy_d;
      sxy_q <= sxy_d;
    end
  end

  assign n      = n_q;
  assign sum_y  = sy_q;
  assign sum_xy = sxy_q;

  // R3: a further sample is only taken while the count is below the programmed one
  a_r3_take_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (n_q < limit));
endmodule

// File: rtl/lse_seq_div.sv
module lse_seq_div #(
  parameter int W = 96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] quo,
  output logic         fin
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  q_q, q_d, r_q, r_d, d_q, d_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d, fin_q, fin_d;
  logic [W:0]    rs, diff;
  logic          ge;

  always_comb begin
    rs     = {r_q, q_q[W-1]};
    diff   = rs - {1'b0, d_q};
    ge     = ~diff[W];
    q_d    = q_q;
    r_d    = r_q;
    d_d    = d_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    fin_d  = 1'b0;
    if (start) begin
      q_d    = dvd;
      r_d    = '0;
      d_d    = dvs;
      cnt_d  = CW'(W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      q_d   = {q_q[W-2:0], ge};
      r_d   = ge ? diff[W-1:0] : rs[W-1:0];
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= '0;
      r_q    <= '0;
      d_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      q_q    <= q_d;
      r_q    <= r_d;
      d_q    <= d_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      fin_q  <= fin_d;
    end
  end

  assign quo = q_q;
  assign fin = fin_q;

  // R2: a finished division leaves a remainder below the divisor
  a_r2_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (r_q < d_q));
endmodule

// File: rtl/lse_freq_est.sv
module lse_freq_est
  import lse_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int CNT_W  = 16,
  parameter int TO_W   = 32,
  parameter int ACC_W  = 64,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_in,
  input  logic              start,
  input  logic [CNT_W-1:0]  sample_count,
  input  logic              halve_rate,
  input  logic [TO_W-1:0]   timeout_limit,
  output logic [TS_W-1:0]   period,
  output logic [FRAC_W-1:0] inv_period_frac,
  output logic [CNT_W-1:0]  n_used,
  output logic              done,
  output logic              timeout,
  output logic              error
);
  localparam int DW = ACC_W + FRAC_W;

  logic [1:0] rs_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  lse_st_e           st_q, st_d;
  logic [TS_W-1:0]   cnt_q;
  logic              pre_q, pre_d;
  logic [CNT_W-1:0]  lim_q, lim_d, nu_q, nu_d;
  logic [TO_W-1:0]   tlim_q, tlim_d, tcnt_q, tcnt_d;
  logic [ACC_W-1:0]  num_q, num_d, den_q, den_d;
  logic [TS_W-1:0]   per_q, per_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic              done_q, done_d, tmo_q, tmo_d, err_q, err_d, pend_q, pend_d;

  logic              ev, arm, ref_ld, take, neg_stop, dstart, dfin;
  logic [CNT_W-1:0]  n;
  logic [ACC_W-1:0]  sum_y, sum_xy, n64, ca, cb, num_w, den_w;
  logic [DW-1:0]     dvd, dvs, quo;
  logic              bad, expired;

  lse_edge_sync u_edge (
    .clk(clk), .rst_n(rst_i), .sig_in(sig_in), .arm(arm),
    .halve(pre_q), .ev(ev)
  );

  lse_accum #(.TS_W(TS_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_i), .clr(arm), .ref_ld(ref_ld), .take(take),
    .stamp(cnt_q), .limit(lim_q), .n(n), .sum_y(sum_y), .sum_xy(sum_xy),
    .neg_stop(neg_stop)
  );

  lse_seq_div #(.W(DW)) u_div (
    .clk(clk), .rst_n(rst_i), .start(dstart), .dvd(dvd), .dvs(dvs),
    .quo(quo), .fin(dfin)
  );

  always_comb begin
    n64     = ACC_W'(n);
    ca      = pre_q ? ACC_W'(6) : ACC_W'(12);
    cb      = pre_q ? ACC_W'(3) : ACC_W'(6);
    num_w   = ca * sum_xy - cb * (n64 + ACC_W'(1)) * sum_y;
    den_w   = n64 * (n64 + ACC_W'(1)) * (n64 - ACC_W'(1));
    bad     = (n < CNT_W'(3)) | num_w[ACC_W-1] | (num_w == '0);
    expired = (tcnt_q >= tlim_q);
  end

  always_comb begin
    st_d   = st_q;
    pre_d  = pre_q;
    lim_d  = lim_q;
    tlim_d = tlim_q;
    tcnt_d = tcnt_q;
    num_d  = num_q;
    den_d  = den_q;
    per_d  = per_q;
    frac_d = frac_q;
    nu_d   = nu_q;
    done_d = done_q;
    tmo_d  = tmo_q;
    err_d  = err_q;
    pend_d = pend_q;
    arm    = 1'b0;
    ref_ld = 1'b0;
    take   = 1'b0;
    dstart = 1'b0;
    dvd    = {{FRAC_W{1'b0}}, num_q};
    dvs    = {{FRAC_W{1'b0}}, den_q};
    case (st_q)
      ST_IDLE: if (start) begin
        arm    = 1'b1;
        pre_d  = halve_rate;
        lim_d  = sample_count;
        tlim_d = timeout_limit;
        tcnt_d = '0;
        per_d  = '0;
        frac_d = '0;
        nu_d   = '0;
        done_d = 1'b0;
        tmo_d  = 1'b0;
        err_d  = 1'b0;
        pend_d = 1'b0;
        st_d   = ST_WREF;
      end
      ST_WREF: begin
        tcnt_d = tcnt_q + TO_W'(1);
        if (ev) begin
          ref_ld = 1'b1;
          if (lim_q <= CNT_W'(1)) st_d = ST_CALC;
        end else if (expired) begin
          pend_d = 1'b1;
          st_d   = ST_CALC;
        end
      end
      ST_COLL: begin
        tcnt_d = tcnt_q + TO_W'(1);
        if (ev && neg_stop) begin
          st_d = ST_CALC;
        end else if (ev) begin
          take = 1'b1;
          if (n + CNT_W'(1) >= lim_q) begin
            st_d = ST_CALC;
          end else if (expired) begin
            pend_d = 1'b1;
            st_d   = ST_CALC;
          end
        end else if (expired) begin
          pend_d = 1'b1;
          st_d   = ST_CALC;
        end
      end
      ST_CALC: begin
        num_d = num_w;
        den_d = den_w;
        nu_d  = n;
        if (bad) begin
          err_d  = 1'b1;
          tmo_d  = pend_q;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          st_d = ST_LD1;
        end
      end
      ST_LD1: begin
        dstart = 1'b1;
        st_d   = ST_WT1;
      end
      ST_WT1: if (dfin) begin
        per_d = (|quo[DW-1:TS_W]) ? {TS_W{1'b1}} : quo[TS_W-1:0];
        st_d  = ST_LD2;
      end
      ST_LD2: begin
        dstart = 1'b1;
        dvd    = {den_q, {FRAC_W{1'b0}}};
        dvs    = {{FRAC_W{1'b0}}, num_q};
        st_d   = ST_WT2;
      end
      ST_WT2: if (dfin) begin
        frac_d = (|quo[DW-1:FRAC_W]) ? {FRAC_W{1'b1}} : quo[FRAC_W-1:0];
        tmo_d  = pend_q;
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    if (st_q != ST_COLL && st_d == ST_COLL) st_d = ST_COLL;
    if (st_q == ST_WREF && ref_ld && st_d == ST_WREF) st_d = ST_COLL;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      pre_q  <= 1'b0;
      lim_q  <= '0;
      tlim_q <= '0;
      tcnt_q <= '0;
      num_q  <= '0;
      den_q  <= '0;
      per_q  <= '0;
      frac_q <= '0;
      nu_q   <= '0;
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      err_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_q + TS_W'(1);
      pre_q  <= pre_d;
      lim_q  <= lim_d;
      tlim_q <= tlim_d;
      tcnt_q <= tcnt_d;
      num_q  <= num_d;
      den_q  <= den_d;
      per_q  <= per_d;
      frac_q <= frac_d;
      nu_q   <= nu_d;
      done_q <= done_d;
      tmo_q  <= tmo_d;
      err_q  <= err_d;
      pend_q <= pend_d;
    end
  end

  assign period          = per_q;
  assign inv_period_frac = frac_q;
  assign n_used          = nu_q;
  assign done            = done_q;
  assign timeout         = tmo_q;
  assign error           = err_q;

  // R7: a reported result stays put until a new start arrives
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_i)
    (done_q && !start) |=> (done_q && $stable(per_q) && $stable(frac_q)));

  // R6: a failed fit reports zero results
  a_r6_error_zeroes: assert property (@(posedge clk) disable iff (!rst_i)
    err_q |-> (per_q == '0 && frac_q == '0));

  // R5: a timeout always means fewer samples than requested
  a_r5_timeout_short: assert property (@(posedge clk) disable iff (!rst_i)
    tmo_q |-> (nu_q < lim_q));
endmodule

// File: tb/tb_lse_freq_est.sv
module tb_lse_freq_est;
  localparam int TSW = 16;
  localparam int CW  = 16;

  logic            clk, rst_n, sig_in, start, halve_rate;
  logic [CW-1:0]   sample_count;
  logic [31:0]     timeout_limit;
  logic [TSW-1:0]  period;
  logic [31:0]     inv_period_frac;
  logic [CW-1:0]   n_used;
  logic            done, timeout, error;

  int n_chk, n_fail, cyc;
  int tm [0:511];

  lse_freq_est #(.TS_W(TSW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .start(start),
    .sample_count(sample_count), .halve_rate(halve_rate),
    .timeout_limit(timeout_limit), .period(period),
    .inv_period_frac(inv_period_frac), .n_used(n_used), .done(done),
    .timeout(timeout), .error(error)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_fit(input int ne, input bit pre, input int cl,
                            output int en, output longint eper, output longint efrac,
                            output bit eerr, output bit etmo);
    int step, avail;
    longint sy, sxy, num, den, nn;
    logic [127:0] big, q;
    step  = pre ? 2 : 1;
    avail = (ne + step - 1) / step;
    en    = (avail == 0) ? 0 : ((avail < (cl < 1 ? 1 : cl)) ? avail : (cl < 1 ? 1 : cl));
    etmo  = (avail < cl);
    sy = 0; sxy = 0;
    for (int k = 0; k < en; k++) begin
      longint y;
      y   = longint'(tm[k*step] - tm[0]);
      sy  += y;
      sxy += longint'(k + 1) * y;
    end
    nn  = longint'(en);
    num = (pre ? 6 : 12) * sxy - (pre ? 3 : 6) * (nn + 1) * sy;
    den = nn * (nn + 1) * (nn - 1);
    eerr = (en < 3) || (num <= 0);
    if (eerr) begin
      eper = 0; efrac = 0;
    end else begin
      eper  = num / den;
      if (eper > 65535) eper = 65535;
      big   = 128'(den) << 32;
      q     = big / 128'(num);
      efrac = (q > 128'h0FFFF_FFFF) ? longint'(32'hFFFF_FFFF) : longint'(q[31:0]);
    end
  endtask

  task automatic run_case(input string tag, input int ne, input bit pre, input int cl,
                          input int tlim, input int pb, input bit jit, input bit mid);
    int en, w, h, l;
    longint eper, efrac;
    bit eerr, etmo;
    @(negedge clk);
    sample_count  = CW'(cl);
    halve_rate    = pre;
    timeout_limit = tlim;
    start         = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0 && n_used == 0 && period == 0, {tag, " R7 cleared on start"},
        longint'(done), 0);
    repeat (4) @(negedge clk);
    for (int i = 0; i < ne; i++) begin
      h = pb / 2;
      l = pb - h;
      if (jit) l = l + int'($urandom % 3) - 1;
      if (l < 1) l = 1;
      sig_in = 1'b1;
      tm[i]  = cyc;
      if (mid && i == ne / 2) start = 1'b1;
      repeat (h) begin @(negedge clk); start = 1'b0; end
      sig_in = 1'b0;
      repeat (l) @(negedge clk);
    end
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    expect_fit(ne, pre, cl, en, eper, efrac, eerr, etmo);
    chk(done == 1'b1, {tag, " R3 done"}, longint'(done), 1);
    chk(n_used == CW'(en), {tag, " R3 n_used"}, longint'(n_used), longint'(en));
    chk(timeout == etmo, {tag, " R5 timeout"}, longint'(timeout), longint'(etmo));
    chk(error == eerr, {tag, " R6 error"}, longint'(error), longint'(eerr));
    chk(longint'(period) == eper, {tag, " R2 period"}, longint'(period), eper);
    chk(longint'(inv_period_frac) == efrac, {tag, " R4 frac"},
        longint'(inv_period_frac), efrac);
  endtask

  initial begin
    int seed_d;
    n_chk = 0; n_fail = 0;
    seed_d = int'($urandom(32'h5EED_1234));
    rst_n = 1'b0; sig_in = 1'b0; start = 1'b0; halve_rate = 1'b0;
    sample_count = '0; timeout_limit = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8: reset state
    chk(done == 0 && timeout == 0 && error == 0, "R8 reset flags", longint'(done), 0);
    chk(period == 0 && inv_period_frac == 0 && n_used == 0, "R8 reset values",
        longint'(period), 0);

    run_case("R2 const p10",       12, 1'b0, 8,  -1,  10, 1'b0, 1'b0);
    run_case("R1 halved p7",       14, 1'b1, 6,  -1,  7,  1'b0, 1'b0);
    run_case("R6 two samples",      5, 1'b0, 2,  -1,  9,  1'b0, 1'b0);
    run_case("R5 short train",      5, 1'b0, 40, 400, 12, 1'b0, 1'b0);
    run_case("R5 no edges",         0, 1'b0, 10, 100, 10, 1'b0, 1'b0);
    run_case("R7 stray start",     14, 1'b0, 10, -1,  9,  1'b1, 1'b0);
    run_case("R1 halved jitter",   26, 1'b1, 12, -1,  11, 1'b1, 1'b0);
    for (int r = 0; r < 8; r++) begin
      int pb, cl;
      bit pre;
      pb  = 6 + int'($urandom % 30);
      cl  = 4 + int'($urandom % 20);
      pre = bit'($urandom % 2);
      run_case($sformatf("R2 random %0d", r), cl * (pre ? 2 : 1) + 2, pre, cl, -1,
               pb, 1'b1, 1'b0);
    end
    while (cyc < 65380) @(negedge clk);
    run_case("R9 counter wrap",    14, 1'b0, 12, -1,  20, 1'b1, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule